// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block keeps a 2048-row DRAM alive. After reset it holds off for a programmable power-up pause and then runs a burst of CAS-before-RAS initialisation cycles. After that it counts out the refresh interval and issues one CAS-before-RAS refresh per interval. All 2048 rows are then covered within the 32 ms retention window, with one refresh due about every 15.6 µs. It does not own the strobes. It raises a request and waits for the access sequencer to grant it the RAS/CAS/WE lines before it drives them.

While the sequencer is busy, missed refresh ticks pile up in a small backlog counter. When the backlog is full, an urgent flag tells the arbiter to let refresh in first. On the grant, the backlog is drained with back-to-back cycles. A level request puts the memory into self-refresh: a CAS-before-RAS cycle with RAS held low for at least a minimum time. On exit the block gives the long precharge and then exactly one catch-up refresh before it releases the strobes. All times are parameters in clock cycles.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted, `ras_n` and `cas_n` are high, and `req`, `urgent`, `ready` and `self_active` are low.
- R2: After reset, `req` stays low for INIT_WAIT cycles. Then INIT_CYCLES refresh cycles are issued. `ready` rises only after the last of them completes, and it stays high from then on.
- R3: In every refresh cycle `cas_n` goes low exactly T_CSR cycles before `ras_n` falls, and it stays low for the whole time `ras_n` is low. A normal cycle keeps `ras_n` low for exactly T_RAS cycles. `we_n` is high at every RAS fall.
- R4: Between two RAS-low pulses, `ras_n` stays high for at least T_RP + T_CSR cycles.
- R5: Once `ready` is high and grants are immediate, successive refresh cycles begin exactly REF_INTERVAL cycles apart.
- R6: The strobes move only while `req` is high, and `req` stays high until the cycle's precharge ends. Without a grant, no cycle starts. `req` falls when no work is left.
- R7: Ticks that are not served add to a backlog that saturates at BACKLOG_MAX. `urgent` is high exactly when the backlog is full, and further ticks are dropped. On a grant the backlog is drained with cycles T_CSR + T_RAS + T_RP + 1 cycles apart.
- R8: If `self_req` is high, `ready` is high and no refresh is pending, the block starts a cycle that holds `ras_n` low for at least SELF_MIN cycles and for as long as `self_req` stays high. If `self_req` is already low when the minimum elapses, the pulse lasts exactly SELF_MIN + 1 cycles. `self_active` is high during the pulse. Pending refreshes are served before self-refresh is entered.
- R9: After self-refresh, `ras_n` stays high for exactly T_RPS + T_CSR cycles. Then exactly one refresh cycle follows, and after that `req` drops.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grant | input | 1 | Sequencer hands the strobes to this block |
| self_req | input | 1 | Level request to stay in self-refresh |
| req | output | 1 | Request for the strobes |
| urgent | output | 1 | Backlog full; refresh must win arbitration |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| ready | output | 1 | Power-up sequence finished |
| self_active | output | 1 | RAS held low in self-refresh |

## Verification
The bench withholds the grant across several intervals to fill the backlog past its limit. A design that did not saturate the backlog would then drain five cycles instead of three, and one that did not raise `urgent` would leave the arbiter blind. It releases `self_req` before the minimum self-refresh time to catch a design that ends the pulse early. It measures the RAS-high gap and the number of cycles after exit, which exposes a missing long precharge or a catch-up cycle that is skipped or repeated. It also enters self-refresh with a refresh pending, so a design that let self-refresh overtake the backlog would show the pulses in the wrong order.

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int INIT_WAIT    = 10000,
  parameter int INIT_CYCLES  = 8,
  parameter int REF_INTERVAL = 780,
  parameter int BACKLOG_MAX  = 4,
  parameter int T_CSR        = 1,
  parameter int T_RAS        = 3,
  parameter int T_RP         = 3,
  parameter int SELF_MIN     = 5000,
  parameter int T_RPS        = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic grant,
  input  logic self_req,
  output logic req,
  output logic urgent,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic ready,
  output logic self_active
);

  localparam int TW = $clog2(INIT_WAIT + SELF_MIN + T_RPS + T_RAS + T_RP + T_CSR + 2);
  localparam int IW = $clog2(REF_INTERVAL + 1);
  localparam int BW = $clog2(BACKLOG_MAX + 1);
  localparam int CW = $clog2(INIT_CYCLES + 1);

  typedef enum logic [2:0] {S_WAIT, S_IDLE, S_CSR, S_RAS, S_SELF, S_SPRE, S_PRE} st_t;

  st_t           st;
  logic [TW-1:0] tmr;
  logic [IW-1:0] itmr;
  logic [BW-1:0] backlog;
  logic [CW-1:0] icnt;
  logic          self_m;

  wire tmr_zero = (tmr == '0);
  wire need     = !ready || (backlog != '0) || self_req;
  wire start    = (st == S_IDLE) && need && grant;
  wire go_self  = ready && (backlog == '0) && self_req;
  wire counting = ready && !self_m;
  wire tick     = counting && (itmr == IW'(REF_INTERVAL - 1));
  wire inc      = tick && (backlog != BW'(BACKLOG_MAX));
  wire dec      = start && ready && (backlog != '0);

  assign req         = (st == S_IDLE) ? need : (st != S_WAIT);
  assign urgent      = (backlog == BW'(BACKLOG_MAX));
  assign cas_n       = !(st inside {S_CSR, S_RAS, S_SELF});
  assign ras_n       = !(st inside {S_RAS, S_SELF});
  assign we_n        = 1'b1;
  assign self_active = self_m && (st inside {S_RAS, S_SELF});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      itmr    <= '0;
      backlog <= '0;
    end else begin
      itmr <= (!counting || tick) ? '0 : itmr + 1'b1;
      if (inc && !dec)      backlog <= backlog + 1'b1;
      else if (dec && !inc) backlog <= backlog - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_WAIT;
      tmr    <= TW'(INIT_WAIT - 1);
      icnt   <= '0;
      ready  <= 1'b0;
      self_m <= 1'b0;
    end else begin
      case (st)
        S_WAIT: if (tmr_zero) st <= S_IDLE; else tmr <= tmr - 1'b1;
        S_IDLE: if (start) begin
          st     <= S_CSR;
          tmr    <= TW'(T_CSR - 1);
          self_m <= go_self;
        end
        S_CSR: if (tmr_zero) begin
          st  <= S_RAS;
          tmr <= self_m ? TW'(SELF_MIN - 1) : TW'(T_RAS - 1);
        end else tmr <= tmr - 1'b1;
        S_RAS: if (tmr_zero) begin
          st  <= self_m ? S_SELF : S_PRE;
          tmr <= TW'(T_RP - 1);
        end else tmr <= tmr - 1'b1;
        S_SELF: if (!self_req) begin
          st  <= S_SPRE;
          tmr <= TW'(T_RPS - 1);
        end
        S_SPRE: if (tmr_zero) begin
          st     <= S_CSR;
          tmr    <= TW'(T_CSR - 1);
          self_m <= 1'b0;
        end else tmr <= tmr - 1'b1;
        S_PRE: if (tmr_zero) begin
          st <= S_IDLE;
          if (!ready) begin
            icnt  <= icnt + 1'b1;
            ready <= (icnt == CW'(INIT_CYCLES - 1));
          end
        end else tmr <= tmr - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_cas_leads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(!cas_n));
  assert_cas_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !cas_n);
  assert_precharge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |=> ras_n);
  assert_strobe_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> $past(req));
  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> req);
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    backlog <= BW'(BACKLOG_MAX));
  assert_urgent_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    urgent |-> req);
  assert_ready_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
  assert_self_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ras_n) && $past(self_active)) |=> (ras_n && req));

endmodule

// File: tb/sim_dram_refresh_sched.sv
`timescale 1ns/1ps
module sim_dram_refresh_sched;
  localparam int INIT_WAIT = 40, INIT_CYCLES = 8, RI = 400, BMAX = 3;
  localparam int T_CSR = 1, T_RAS = 3, T_RP = 2, SELF_MIN = 40, T_RPS = 4;

  logic clk = 1'b0, rst_n = 1'b0, allow = 1'b1, self_req = 1'b0;
  logic req, urgent, ras_n, cas_n, we_n, ready, self_active, grant;
  assign grant = req & allow;

  always #10 clk = ~clk;

  dram_refresh_sched #(.INIT_WAIT(INIT_WAIT), .INIT_CYCLES(INIT_CYCLES), .REF_INTERVAL(RI),
    .BACKLOG_MAX(BMAX), .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP), .SELF_MIN(SELF_MIN),
    .T_RPS(T_RPS)) u0 (.clk(clk), .rst_n(rst_n), .grant(grant), .self_req(self_req),
    .req(req), .urgent(urgent), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ready(ready),
    .self_active(self_active));

  int nchecks = 0, nfail = 0;
  int q_lo[$], q_hi[$];
  string q_tag[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input int lo, input int hi, input string tag);
    q_lo.push_back(lo); q_hi.push_back(hi); q_tag.push_back(tag);
  endtask

  // monitor
  int cyc = 0, lead = 0, lowlen = 0, gap = 0, done = 0, last_fall = 0, prev_fall = 0;
  bit prev_ras = 1'b1, cas_ok = 1'b1, seen = 1'b0, prev_self = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (ras_n) begin
        if (!prev_ras) begin
          if (q_lo.size() == 0) chk(0, "R6 unexpected pulse", lowlen, 0);
          else begin
            int lo, hi; string tg;
            lo = q_lo.pop_front(); hi = q_hi.pop_front(); tg = q_tag.pop_front();
            chk(lowlen >= lo && lowlen <= hi, tg, lowlen, lo);
          end
          chk(cas_ok, "R3 cas low through pulse", cas_ok, 1);
          done++;
          prev_self = (lowlen > T_RAS);
          seen = 1'b1;
          gap = 0;
        end
        gap++;
        if (!cas_n) lead++; else lead = 0;
      end else begin
        if (prev_ras) begin
          chk(lead == T_CSR, "R3 cas lead", lead, T_CSR);
          chk(we_n == 1'b1, "R3 we high", we_n, 1);
          if (seen) chk(gap >= T_RP + T_CSR, "R4 precharge", gap, T_RP + T_CSR);
          if (seen && prev_self) chk(gap == T_RPS + T_CSR, "R9 exit precharge", gap, T_RPS + T_CSR);
          prev_fall = last_fall; last_fall = cyc;
          lowlen = 0; cas_ok = 1'b1;
        end
        lowlen++;
        if (cas_n) cas_ok = 1'b0;
      end
      prev_ras = ras_n;
    end
  end

  task automatic wait_done(input int target, input string tag);
    int n = 0;
    while (done < target && n < 5000) begin @(negedge clk); n++; end
    chk(done == target, tag, done, target);
  endtask

  task automatic wait_req_low(input string tag);
    int n = 0;
    while (req && n < 1000) begin @(negedge clk); n++; end
    chk(!req, tag, req, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n, "R1 strobes idle", {ras_n, cas_n}, 3);
    chk(!req && !urgent && !ready && !self_active, "R1 outputs low",
        {req, urgent, ready, self_active}, 0);
    for (int i = 0; i < INIT_CYCLES; i++) push(T_RAS, T_RAS, "R2 init pulse");
    rst_n = 1'b1;
    n = 0;
    while (!req && n < 1000) begin @(negedge clk); n++; end
    chk(n >= INIT_WAIT && n <= INIT_WAIT + 1, "R2 power-up pause", n, INIT_WAIT);
    chk(!ready, "R2 not ready during init", ready, 0);
    n = 0;
    while (!ready && n < 2000) begin @(negedge clk); n++; end
    chk(done == INIT_CYCLES, "R2 init count at ready", done, INIT_CYCLES);

    for (int i = 0; i < 3; i++) push(T_RAS, T_RAS, "R3 refresh pulse");
    wait_done(INIT_CYCLES + 3, "R5 periodic pulses");
    chk(last_fall - prev_fall == RI, "R5 interval", last_fall - prev_fall, RI);
    allow = 1'b0;

    repeat (RI + 20) @(negedge clk);
    chk(req, "R6 request while held off", req, 1);
    chk(!urgent, "R7 urgent low below limit", urgent, 0);
    n = 0;
    while (!urgent && n < 5 * RI) begin @(negedge clk); n++; end
    repeat (2 * RI + 10) @(negedge clk);
    chk(urgent, "R7 urgent at limit", urgent, 1);
    chk(done == INIT_CYCLES + 3 && ras_n, "R6 no cycle without grant", done, INIT_CYCLES + 3);
    for (int i = 0; i < BMAX; i++) push(T_RAS, T_RAS, "R7 drain pulse");
    allow = 1'b1;
    repeat (40) @(negedge clk);
    chk(done == INIT_CYCLES + 6, "R7 saturated drain count", done, INIT_CYCLES + 6);
    chk(last_fall - prev_fall == T_CSR + T_RAS + T_RP + 1, "R7 back-to-back",
        last_fall - prev_fall, T_CSR + T_RAS + T_RP + 1);
    chk(!urgent, "R7 urgent cleared", urgent, 0);
    chk(!req, "R6 req released", req, 0);

    push(SELF_MIN + 1, SELF_MIN + 1, "R8 short self pulse");
    push(T_RAS, T_RAS, "R9 catch-up pulse");
    self_req = 1'b1;
    repeat (10) @(negedge clk);
    chk(!ras_n && self_active, "R8 in self-refresh", {ras_n, self_active}, 1);
    self_req = 1'b0;
    wait_req_low("R9 release after exit");
    chk(done == INIT_CYCLES + 8, "R9 one catch-up", done, INIT_CYCLES + 8);
    repeat (20) @(negedge clk);
    chk(done == INIT_CYCLES + 8 && ras_n, "R9 no extra cycle", done, INIT_CYCLES + 8);
    chk(ready, "R2 ready sticky", ready, 1);

    push(145, 152, "R8 long self pulse");
    push(T_RAS, T_RAS, "R9 catch-up pulse");
    self_req = 1'b1;
    repeat (150) @(negedge clk);
    self_req = 1'b0;
    wait_req_low("R9 release after long self");
    chk(done == INIT_CYCLES + 10, "R9 long self count", done, INIT_CYCLES + 10);

    allow = 1'b0;
    repeat (RI + 5) @(negedge clk);
    chk(req && !urgent, "R7 one pending", {req, urgent}, 2);
    push(T_RAS, T_RAS, "R8 pending served first");
    push(SELF_MIN + 1, SELF_MIN + 1, "R8 self after pending");
    push(T_RAS, T_RAS, "R9 catch-up pulse");
    self_req = 1'b1;
    allow = 1'b1;
    repeat (20) @(negedge clk);
    self_req = 1'b0;
    wait_req_low("R9 release after ordered self");
    chk(done == INIT_CYCLES + 13, "R8 ordered count", done, INIT_CYCLES + 13);
    chk(q_lo.size() == 0, "R6 all expected pulses seen", q_lo.size(), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end
endmodule